// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block is the enhanced-mode access path of a host parallel port. A host issues single-cycle requests at small register offsets. Three offsets hold plain registers: the output data byte, the status view and the control byte. Two more offsets start enhanced-mode transfers to the attached peripheral. Offset 3 runs an address cycle. Offset 4 runs a data cycle of one, two or four bytes.

A transfer starts only when the control byte holds the exact pattern for its direction. Each byte then goes through a request/acknowledge handshake with the peripheral. That handshake is bounded by a cycle limit the integrator sets. When a byte is not acknowledged in time, the block sets a sticky timeout flag, drops the bytes that remain and completes the host access at once. Status reads show the flag in bit 0. A status write with bit 0 set clears it.

Control and data writes that change nothing produce no peripheral activity. A control write that flips the direction bit raises a separate indication so the peripheral can turn its data bus around.

Top module: `epp_gate`

## Requirements
- R1: After reset the control byte reads 0xCC, the output data byte reads 0xFF, status bit 0 reads 0 and per_req is low.
- R2: Offset 0 is the output data byte, offset 1 is status, offset 2 is control, offset 3 is a single-byte address cycle (per_addr_cyc=1) and offset 4 is a data cycle. Reads of offsets 5 to 7 return 0xFF, and writes to them have no effect.
- R3: An enhanced-mode write runs only when (control & 0x2F) == 0x04. In any other state it produces no peripheral request.
- R4: An enhanced-mode read runs only when (control & 0x2F) == 0x24. In any other state it produces no request and returns all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF, with zeros above.
- R5: A failed byte sets a sticky timeout flag. A status read returns per_status[7:1] in bits 7:1 and the flag in bit 0.
- R6: Only a status write with bit 0 = 1 clears the flag. A status write with bit 0 = 0 leaves it unchanged.
- R7: host_size 0, 1 and 2 (or 3) move 1, 2 and 4 bytes at offset 4, lowest byte first. Read bytes fill host_rdata from bit 0 upward, and the bits above the width are zero. per_wdata holds steady while per_req is high.
- R8: per_req stays high for at most max(cfg_limit,1) cycles per byte. An acknowledge sampled in any of those cycles completes the byte. Otherwise the byte fails. per_req drops for one cycle between bytes.
- R9: After a failure, no further byte of that access is requested and host_done pulses. Read bytes not received return as ones.
- R10: Control writes force bits 7:6 to 1. A result equal to the current control value gives no ctrl_upd pulse. A change of bit 5 (direction) gives a dir_chg pulse together with ctrl_upd.
- R11: A write to offset 0 equal to the current output byte gives no data_upd pulse. A different value updates data_q and pulses data_upd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_limit | input | LIM_W | Handshake cycle limit per byte |
| host_req | input | 1 | Access request, one cycle, sampled only when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | Offset-4 width: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| host_wdata | input | 32 | Write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_done |
| ctrl_q | output | 8 | Current control byte |
| ctrl_upd | output | 1 | Pulse: control byte changed |
| dir_chg | output | 1 | Pulse: direction bit changed |
| data_q | output | 8 | Current output data byte |
| data_upd | output | 1 | Pulse: output data byte changed |
| per_req | output | 1 | Byte transfer request to the peripheral |
| per_addr_cyc | output | 1 | Current transfer is an address cycle |
| per_we | output | 1 | Current transfer writes to the peripheral |
| per_wdata | output | 8 | Byte being written |
| per_ack | input | 1 | Peripheral acknowledge |
| per_rdata | input | 8 | Byte returned by the peripheral |
| per_status | input | 8 | Raw peripheral status lines |

## Verification
The hardest situations to reach are a timeout in the middle of a multi-byte access and the exact edge of the cycle limit. The bench's peripheral model can acknowledge after a chosen delay or never. The stimulus withholds the acknowledge during a four-byte write to show that only one request appears. It then sets the limit to 4 and uses delays one apart that straddle the limit, so one byte just succeeds and the next just fails.

// File: rtl/epp_gate.sv
module epp_gate #(
  parameter int          LIM_W    = 8,
  parameter logic [7:0]  CTRL_RST = 8'hCC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic             host_req,
  input  logic             host_we,
  input  logic [2:0]       host_addr,
  input  logic [1:0]       host_size,
  input  logic [31:0]      host_wdata,
  output logic             host_done,
  output logic [31:0]      host_rdata,
  output logic [7:0]       ctrl_q,
  output logic             ctrl_upd,
  output logic             dir_chg,
  output logic [7:0]       data_q,
  output logic             data_upd,
  output logic             per_req,
  output logic             per_addr_cyc,
  output logic             per_we,
  output logic [7:0]       per_wdata,
  input  logic             per_ack,
  input  logic [7:0]       per_rdata,
  input  logic [7:0]       per_status
);

  localparam logic [7:0] GATE_MASK = 8'h2F;
  localparam logic [7:0] GATE_WR   = 8'h04;
  localparam logic [7:0] GATE_RD   = 8'h24;
  localparam int         CW        = LIM_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_GAP} st_t;

  st_t              st;
  logic [LIM_W-1:0] cnt;
  logic [1:0]       idx, last;
  logic [31:0]      wbuf;
  logic             tmo_q;
  logic [7:0]       ctrl_nv;
  logic             gate_ok, expire;
  logic [1:0]       last_nv;

  function automatic logic [31:0] ones_for(input logic [1:0] n);
    case (n)
      2'd0:    ones_for = 32'h0000_00FF;
      2'd1:    ones_for = 32'h0000_FFFF;
      default: ones_for = 32'hFFFF_FFFF;
    endcase
  endfunction

  assign ctrl_nv = host_wdata[7:0] | 8'hC0;
  assign gate_ok = host_we ? ((ctrl_q & GATE_MASK) == GATE_WR)
                           : ((ctrl_q & GATE_MASK) == GATE_RD);
  assign last_nv = (host_addr == 3'd3) ? 2'd0 :
                   (host_size == 2'd0) ? 2'd0 :
                   (host_size == 2'd1) ? 2'd1 : 2'd3;
  assign expire  = ({1'b0, cnt} + CW'(1)) >= {1'b0, cfg_limit};

  assign per_req   = (st == S_REQ);
  assign per_wdata = wbuf[idx*8 +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      idx          <= '0;
      last         <= '0;
      wbuf         <= '0;
      tmo_q        <= 1'b0;
      ctrl_q       <= CTRL_RST;
      data_q       <= 8'hFF;
      host_done    <= 1'b0;
      host_rdata   <= '0;
      ctrl_upd     <= 1'b0;
      dir_chg      <= 1'b0;
      data_upd     <= 1'b0;
      per_addr_cyc <= 1'b0;
      per_we       <= 1'b0;
    end else begin
      host_done <= 1'b0;
      ctrl_upd  <= 1'b0;
      dir_chg   <= 1'b0;
      data_upd  <= 1'b0;
      case (st)
        S_IDLE: if (host_req) begin
          host_rdata <= '0;
          case (host_addr)
            3'd0: begin
              host_done <= 1'b1;
              if (host_we) begin
                if (host_wdata[7:0] != data_q) begin
                  data_q   <= host_wdata[7:0];
                  data_upd <= 1'b1;
                end
              end else begin
                host_rdata <= {24'h0, ctrl_q[5] ? per_rdata : data_q};
              end
            end
            3'd1: begin
              host_done <= 1'b1;
              if (host_we) begin
                if (host_wdata[0]) tmo_q <= 1'b0;
              end else begin
                host_rdata <= {24'h0, per_status[7:1], tmo_q};
              end
            end
            3'd2: begin
              host_done <= 1'b1;
              if (host_we) begin
                if (ctrl_nv != ctrl_q) begin
                  ctrl_q   <= ctrl_nv;
                  ctrl_upd <= 1'b1;
                  dir_chg  <= ctrl_nv[5] ^ ctrl_q[5];
                end
              end else begin
                host_rdata <= {24'h0, ctrl_q};
              end
            end
            3'd3, 3'd4: begin
              if (!host_we) host_rdata <= ones_for(last_nv == 2'd3 ? 2'd2 : last_nv);
              if (gate_ok) begin
                st           <= S_REQ;
                cnt          <= '0;
                idx          <= '0;
                last         <= last_nv;
                wbuf         <= host_wdata;
                per_we       <= host_we;
                per_addr_cyc <= (host_addr == 3'd3);
              end else begin
                host_done <= 1'b1;
              end
            end
            default: begin
              host_done <= 1'b1;
              if (!host_we) host_rdata <= 32'h0000_00FF;
            end
          endcase
        end
        S_REQ: begin
          if (per_ack) begin
            if (!per_we) host_rdata[idx*8 +: 8] <= per_rdata;
            if (idx == last) begin
              st        <= S_IDLE;
              host_done <= 1'b1;
            end else begin
              st  <= S_GAP;
              idx <= idx + 2'd1;
            end
          end else if (expire) begin
            tmo_q     <= 1'b1;
            st        <= S_IDLE;
            host_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GAP: begin
          st  <= S_REQ;
          cnt <= '0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/epp_gate_chk.sv
module epp_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  ctrl_q,
  input logic        ctrl_upd,
  input logic        dir_chg,
  input logic [7:0]  data_q,
  input logic        data_upd,
  input logic        per_req,
  input logic        per_we,
  input logic        per_ack,
  input logic [7:0]  per_wdata,
  input logic        tmo,
  input logic        host_req,
  input logic        host_we,
  input logic [2:0]  host_addr,
  input logic [31:0] host_wdata
);

  AST_WR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(per_req) && per_we) |-> ((ctrl_q & 8'h2F) == 8'h04)); // R3

  AST_RD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(per_req) && !per_we) |-> ((ctrl_q & 8'h2F) == 8'h24)); // R4

  AST_TMO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> ($past(per_req) && !$past(per_ack))); // R5

  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo) |-> $past(host_req && host_we && host_addr == 3'd1 && host_wdata[0])); // R6

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (per_req && $past(per_req)) |-> $stable(per_wdata)); // R7

  AST_DIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_chg |-> (ctrl_upd && ctrl_q[5] != $past(ctrl_q[5]))); // R10

  AST_DATA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_upd |-> (data_q != $past(data_q))); // R11

endmodule

bind epp_gate epp_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .ctrl_upd(ctrl_upd),
  .dir_chg(dir_chg), .data_q(data_q), .data_upd(data_upd),
  .per_req(per_req), .per_we(per_we), .per_ack(per_ack),
  .per_wdata(per_wdata), .tmo(tmo_q), .host_req(host_req),
  .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata)
);

// File: tb/epp_gate_test.sv
module epp_gate_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  cfg_limit = 8'd16;
  logic        host_req = 0, host_we = 0;
  logic [2:0]  host_addr = 0;
  logic [1:0]  host_size = 0;
  logic [31:0] host_wdata = 0;
  logic        host_done;
  logic [31:0] host_rdata;
  logic [7:0]  ctrl_q, data_q, per_wdata, per_rdata;
  logic        ctrl_upd, dir_chg, data_upd, per_req, per_addr_cyc, per_we;
  logic        per_ack = 0;
  logic [7:0]  per_status = 8'h5A;

  int checks = 0, fails = 0;
  int wcnt = 0, ack_delay = 1, ack_cnt = 0, nreq = 0, nlog = 0;
  int n_cupd = 0, n_dir = 0, n_dupd = 0;
  bit ack_en = 1, prev_req = 0;
  logic [8:0] log_q [64];
  logic [31:0] rd;

  always #10 clk = ~clk;

  epp_gate uut (.*);

  assign per_rdata = 8'h30 + ack_cnt[7:0];

  always @(posedge clk) begin
    prev_req <= per_req;
    if (per_req && !prev_req) nreq <= nreq + 1;
    if (ctrl_upd) n_cupd <= n_cupd + 1;
    if (dir_chg)  n_dir  <= n_dir + 1;
    if (data_upd) n_dupd <= n_dupd + 1;
    if (!per_req) begin
      per_ack <= 0; wcnt <= 0;
    end else if (!per_ack) begin
      if (ack_en && wcnt == ack_delay) per_ack <= 1;
      else wcnt <= wcnt + 1;
    end
    if (per_req && per_ack) begin
      log_q[nlog] <= {per_addr_cyc, per_wdata};
      nlog <= nlog + 1;
      ack_cnt <= ack_cnt + 1;
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [2:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] r);
    int w;
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_req = 0;
    w = 0;
    while (!host_done && w < 200) begin @(negedge clk); w++; end
    chk(host_done, "host_done seen", {31'h0, host_done}, 32'h1);
    r = host_rdata;
    @(negedge clk);
  endtask

  localparam int NV = 14;
  localparam logic [69:0] VEC [NV] = '{
    {1'b0, 3'd2, 2'd0, 32'h0, 32'h0000_00CC},
    {1'b0, 3'd1, 2'd0, 32'h0, 32'h0000_005A},
    {1'b0, 3'd4, 2'd2, 32'h0, 32'hFFFF_FFFF},
    {1'b0, 3'd4, 2'd1, 32'h0, 32'h0000_FFFF},
    {1'b0, 3'd3, 2'd2, 32'h0, 32'h0000_00FF},
    {1'b0, 3'd6, 2'd0, 32'h0, 32'h0000_00FF},
    {1'b1, 3'd6, 2'd0, 32'h0, 32'h0},
    {1'b1, 3'd2, 2'd0, 32'h24, 32'h0},
    {1'b0, 3'd2, 2'd0, 32'h0, 32'h0000_00E4},
    {1'b1, 3'd2, 2'd0, 32'h04, 32'h0},
    {1'b0, 3'd4, 2'd0, 32'h0, 32'h0000_00FF},
    {1'b1, 3'd2, 2'd0, 32'h0D, 32'h0},
    {1'b0, 3'd2, 2'd0, 32'h0, 32'h0000_00CD},
    {1'b0, 3'd0, 2'd0, 32'h0, 32'h0000_00FF}
  };

  initial begin
    int base, q0;
    logic [31:0] expv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ctrl_q == 8'hCC && data_q == 8'hFF && !per_req, "R1 reset state", {16'h0, ctrl_q, data_q}, 32'hCCFF);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][69], VEC[i][68:66], VEC[i][65:64], VEC[i][63:32], rd);
      if (!VEC[i][69])
        chk(rd == VEC[i][31:0], $sformatf("R1/R2/R4/R10 table entry %0d", i), rd, VEC[i][31:0]);
    end
    chk(nreq == 0, "R3 R4 gated accesses made no request", nreq, 0);

    acc(1, 3'd2, 0, 32'h04, rd);
    acc(1, 3'd4, 2, 32'h1122_3344, rd);
    chk(nlog == 4, "R7 four bytes moved", nlog, 4);
    chk({log_q[0][7:0], log_q[1][7:0], log_q[2][7:0], log_q[3][7:0]} == 32'h4433_2211,
        "R7 byte order lowest first",
        {log_q[0][7:0], log_q[1][7:0], log_q[2][7:0], log_q[3][7:0]}, 32'h4433_2211);
    chk(nreq == 4, "R8 separate request per byte", nreq, 4);

    acc(1, 3'd3, 2, 32'h005A_5A55, rd);
    chk(nlog == 5 && log_q[4] == 9'h155, "R2 address cycle single byte", {23'h0, log_q[4]}, 32'h155);

    acc(1, 3'd2, 0, 32'h05, rd);
    acc(1, 3'd4, 0, 32'h99, rd);
    chk(nreq == 5, "R3 write blocked with strobe bit set", nreq, 5);

    acc(1, 3'd2, 0, 32'h24, rd);
    base = ack_cnt;
    acc(0, 3'd4, 2, 0, rd);
    expv = {8'(8'h33 + base), 8'(8'h32 + base), 8'(8'h31 + base), 8'(8'h30 + base)};
    chk(rd == expv, "R7 four-byte read assembly", rd, expv);
    base = ack_cnt;
    acc(0, 3'd4, 1, 0, rd);
    expv = {16'h0, 8'(8'h31 + base), 8'(8'h30 + base)};
    chk(rd == expv, "R7 two-byte read upper bits zero", rd, expv);

    acc(1, 3'd2, 0, 32'h04, rd);
    ack_en = 0;
    q0 = nreq;
    acc(1, 3'd4, 2, 32'hDEAD_BEEF, rd);
    chk(nreq == q0 + 1, "R9 remaining bytes abandoned", nreq, q0 + 1);
    acc(0, 3'd1, 0, 0, rd);
    chk(rd == 32'h5B, "R5 timeout flag in status bit0", rd, 32'h5B);
    acc(1, 3'd1, 0, 32'hFE, rd);
    acc(0, 3'd1, 0, 0, rd);
    chk(rd == 32'h5B, "R6 status write bit0=0 keeps flag", rd, 32'h5B);
    acc(1, 3'd1, 0, 32'h01, rd);
    acc(0, 3'd1, 0, 0, rd);
    chk(rd == 32'h5A, "R6 status write bit0=1 clears flag", rd, 32'h5A);

    acc(1, 3'd2, 0, 32'h24, rd);
    acc(0, 3'd4, 1, 0, rd);
    chk(rd == 32'h0000_FFFF, "R9 failed read returns ones", rd, 32'h0000_FFFF);
    acc(0, 3'd1, 0, 0, rd);
    chk(rd == 32'h5B, "R5 read failure sets flag", rd, 32'h5B);
    acc(1, 3'd1, 0, 32'h01, rd);

    acc(1, 3'd2, 0, 32'h04, rd);
    ack_en = 1; cfg_limit = 8'd4; ack_delay = 2;
    acc(1, 3'd4, 0, 32'h12, rd);
    acc(0, 3'd1, 0, 0, rd);
    chk(rd == 32'h5A, "R8 ack in last allowed cycle succeeds", rd, 32'h5A);
    ack_delay = 3;
    acc(1, 3'd4, 0, 32'h13, rd);
    acc(0, 3'd1, 0, 0, rd);
    chk(rd == 32'h5B, "R8 ack one cycle late fails", rd, 32'h5B);
    acc(1, 3'd1, 0, 32'h01, rd);
    cfg_limit = 8'd16; ack_delay = 1;

    q0 = n_cupd;
    acc(1, 3'd2, 0, 32'hC4, rd);
    chk(n_cupd == q0, "R10 equal control write suppressed", n_cupd, q0);
    q0 = n_dir;
    acc(1, 3'd2, 0, 32'h24, rd);
    chk(n_dir == q0 + 1, "R10 direction change pulse", n_dir, q0 + 1);
    q0 = n_dir;
    acc(1, 3'd2, 0, 32'h2C, rd);
    chk(n_dir == q0, "R10 no dir pulse without direction change", n_dir, q0);

    q0 = n_dupd;
    acc(1, 3'd0, 0, 32'h77, rd);
    acc(1, 3'd0, 0, 32'h77, rd);
    chk(n_dupd == q0 + 1 && data_q == 8'h77, "R11 repeated data write suppressed", n_dupd, q0 + 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule